// File: doc/BRIEF.md
# Per-Subcarrier Pseudo-Random Pair Generator

This block supplies a two-bit pseudo-random value for every subcarrier of a multicarrier symbol; a later stage uses the value to rotate that subcarrier's constellation point. An 11-bit linear feedback shift register produces two bits each clock cycle. After a symbol-start pulse the block walks through subcarriers 0 to N-1, one per cycle, and presents each value together with its subcarrier index and a valid strobe.

The register can be reseeded at every symbol, which gives every symbol the same sequence. It can also run freely, so that each symbol takes the bits that follow those of the previous one. Symbol positions that are not flagged active leave the register frozen. The DC subcarrier always reads 00. Subcarriers whose in-use flag is clear produce no valid strobe. Both cases still consume their two scrambler bits.

Top module: `sc_prbs_gen`

## Requirements
- R1: While `rst` is high the register loads `seed_i` and `out_valid_o` is low. After reset the block stays idle and emits nothing until an active symbol start.
- R2: Suppose `sym_start_i` and `sym_active_i` are both high at clock edge E. Then subcarrier i (0 to N-1) is presented on `out_idx_o` at edge E+1+i, one subcarrier per cycle, and the symbol ends after subcarrier N-1.
- R3: Scrambler bits come from an 11-bit state s[10:0]. Each new bit is s[10] XOR s[1] (polynomial x^11 + x^2 + 1) and is shifted in at s[0]. Subcarrier i takes bits b(2i) and b(2i+1), with `out_bits_o[1]` = b(2i) and `out_bits_o[0]` = b(2i+1).
- R4: Subcarrier 0 always shows `out_bits_o` = 00, yet its two scrambler bits are still consumed.
- R5: When `used_mask_i[i]` is 0, subcarrier i raises no `out_valid_o`, yet its two bits are still consumed.
- R6: With `free_run_i` = 0 at an active symbol start, the register reloads `seed_i`, so every such symbol yields the same 2N-bit sequence.
- R7: With `free_run_i` = 1 at an active symbol start, there is no reload, and the symbol continues with the bits that follow the last ones consumed.
- R8: A symbol start with `sym_active_i` = 0 emits nothing and leaves the register unchanged until the next active start. Idle cycles also leave it unchanged.
- R9: A symbol start during a running symbol finishes the current subcarrier and then restarts at subcarrier 0. In reseed mode it also reloads the seed.
- R10: `seed_i` and `free_run_i` are acted on only at a symbol start (or at reset). Changes in mid-symbol do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_start_i | input | 1 | Symbol start pulse |
| sym_active_i | input | 1 | Symbol position is active, sampled with the start pulse |
| free_run_i | input | 1 | 1 = free-running, 0 = reseed every symbol |
| seed_i | input | 11 | Seed value for the register |
| used_mask_i | input | N | Per-subcarrier in-use flags |
| out_valid_o | output | 1 | Value for an in-use subcarrier is present |
| out_idx_o | output | log2(N) | Subcarrier index of the present value |
| out_bits_o | output | 2 | Two-bit pseudo-random value |

## Verification
A start sampled at edge E produces the result for subcarrier i at edge E+1+i. The register moves at the same edges, so a restart or a reload takes effect on the value that appears one edge after the start. The bench applies inputs at the falling edge and compares outputs at the next falling edge, against expectations that a bench-side model computed at stimulus time for the edge in between. It therefore always samples exactly one register stage after the stimulus. Comparisons between symbols use values captured at those same points.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int LFSR_W = 11;
    localparam int BITS_PER_SC = 2;

    typedef logic [LFSR_W-1:0] lfsr_t;
    typedef logic [BITS_PER_SC-1:0] pair_t;

    typedef struct packed {
        lfsr_t nxt;
        pair_t pair;
    } step_t;

    // Two Fibonacci steps of x^11 + x^2 + 1; first bit lands in pair[1]
    function automatic step_t lfsr_step2(lfsr_t cur);
        step_t res;
        lfsr_t s;
        logic fb;
        s = cur;
        res.pair = '0;
        for (int k = 0; k < BITS_PER_SC; k++) begin
            fb = s[LFSR_W-1] ^ s[1];
            res.pair[BITS_PER_SC-1-k] = fb;
            s = {s[LFSR_W-2:0], fb};
        end
        res.nxt = s;
        return res;
    endfunction

endpackage

// File: rtl/scr_sym_ctrl.sv
module scr_sym_ctrl #(
    parameter int N = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sym_start,
    input  logic             sym_active,
    input  logic             free_run,
    output logic             run,
    output logic [IDX_W-1:0] idx,
    output logic             load,
    output logic             adv
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    // Reseed only when an active symbol begins in reseed mode
    assign load = sym_start & sym_active & ~free_run;
    // A running cycle always consumes its two bits unless a reload wins
    assign adv  = run & ~load;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            idx <= '0;
        end else if (sym_start) begin
            run <= sym_active;
            idx <= '0;
        end else if (run) begin
            if (idx == LAST) run <= 1'b0;
            idx <= idx + 1'b1;
        end
    end

    a_r9_restart: assert property (@(posedge clk) disable iff (rst)
        (sym_start && sym_active) |=> (run && idx == '0));

    a_r8_inactive_idle: assert property (@(posedge clk) disable iff (rst)
        (sym_start && !sym_active) |=> !run);

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (run && !sym_start && idx != LAST) |=> (run && idx == $past(idx) + 1'b1));

    a_r2_end: assert property (@(posedge clk) disable iff (rst)
        (run && !sym_start && idx == LAST) |=> !run);

endmodule

// File: rtl/scr_lfsr.sv
module scr_lfsr
    import scr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  lfsr_t seed,
    input  logic  load,
    input  logic  adv,
    output pair_t pair
);

    lfsr_t state;
    step_t step;

    always_comb step = lfsr_step2(state);
    assign pair = step.pair;

    always_ff @(posedge clk) begin
        if (rst)       state <= seed;
        else if (load) state <= seed;
        else if (adv)  state <= step.nxt;
    end

    a_r6_reload: assert property (@(posedge clk) disable iff (rst)
        load |=> (state == $past(seed)));

    a_r8_freeze: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv) |=> $stable(state));

    a_r7_shift: assert property (@(posedge clk) disable iff (rst)
        (adv && !load) |=> (state[LFSR_W-1:2] == $past(state[LFSR_W-3:0])));

endmodule

// File: rtl/scr_out_stage.sv
module scr_out_stage
    import scr_pkg::*;
#(
    parameter int N = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [IDX_W-1:0] idx,
    input  pair_t            pair,
    input  logic [N-1:0]     used_mask,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o,
    output pair_t            bits_o
);

    logic  sc_used;
    logic  is_dc;
    pair_t masked;

    always_comb begin
        sc_used = used_mask[idx];
        is_dc   = (idx == '0);
        masked  = is_dc ? '0 : pair;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            idx_o   <= '0;
            bits_o  <= '0;
        end else begin
            valid_o <= run & sc_used;
            if (run) begin
                idx_o  <= idx;
                bits_o <= masked;
            end
        end
    end

    a_r5_unused_quiet: assert property (@(posedge clk) disable iff (rst)
        (run && !used_mask[idx]) |=> !valid_o);

    a_r2_idx_follow: assert property (@(posedge clk) disable iff (rst)
        run |=> (idx_o == $past(idx)));

    a_r2_no_run_no_valid: assert property (@(posedge clk) disable iff (rst)
        !run |=> !valid_o);

endmodule

// File: rtl/sc_prbs_gen.sv
module sc_prbs_gen
    import scr_pkg::*;
#(
    parameter int N = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sym_start_i,
    input  logic             sym_active_i,
    input  logic             free_run_i,
    input  logic [10:0]      seed_i,
    input  logic [N-1:0]     used_mask_i,
    output logic             out_valid_o,
    output logic [IDX_W-1:0] out_idx_o,
    output logic [1:0]       out_bits_o
);

    logic             run;
    logic [IDX_W-1:0] idx;
    logic             load;
    logic             adv;
    pair_t            pair;

    scr_sym_ctrl #(.N(N), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sym_start  (sym_start_i),
        .sym_active (sym_active_i),
        .free_run   (free_run_i),
        .run        (run),
        .idx        (idx),
        .load       (load),
        .adv        (adv)
    );

    scr_lfsr u_lfsr (
        .clk  (clk),
        .rst  (rst),
        .seed (seed_i),
        .load (load),
        .adv  (adv),
        .pair (pair)
    );

    scr_out_stage #(.N(N), .IDX_W(IDX_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .idx       (idx),
        .pair      (pair),
        .used_mask (used_mask_i),
        .valid_o   (out_valid_o),
        .idx_o     (out_idx_o),
        .bits_o    (out_bits_o)
    );

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> !out_valid_o);

    a_r4_dc_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && out_idx_o == '0) |-> (out_bits_o == 2'b00));

endmodule

// File: tb/sc_prbs_gen_tb.sv
`timescale 1ns/1ps
module sc_prbs_gen_tb;

    localparam int N  = 16;
    localparam int IW = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst;
    logic          sym_start, sym_active, free_run;
    logic [10:0]   seed;
    logic [N-1:0]  used;
    logic          ov;
    logic [IW-1:0] oi;
    logic [1:0]    ob;

    sc_prbs_gen #(.N(N)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .sym_start_i  (sym_start),
        .sym_active_i (sym_active),
        .free_run_i   (free_run),
        .seed_i       (seed),
        .used_mask_i  (used),
        .out_valid_o  (ov),
        .out_idx_o    (oi),
        .out_bits_o   (ob)
    );

    int errors = 0;
    int checks = 0;

    logic [10:0]  t_seed;
    logic         t_free;
    logic [N-1:0] t_used;

    logic [10:0]   m_state;
    logic          m_run;
    logic [IW-1:0] m_idx;
    logic          e_valid;
    logic [IW-1:0] e_idx;
    logic [1:0]    e_bits;
    string         e_tag;
    int            e_sel;
    string         tag;
    int            cap_sel;
    logic [1:0]    cap [0:3][0:N-1];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Two scrambler bits per R3, returned as {b_even, b_odd, next_state}
    function automatic logic [12:0] ref2(input logic [10:0] s);
        logic [10:0] t;
        logic a, b;
        t = s;
        a = t[10] ^ t[1];
        t = {t[9:0], a};
        b = t[10] ^ t[1];
        t = {t[9:0], b};
        return {a, b, t};
    endfunction

    task automatic cyc(input logic st, input logic act);
        logic [12:0] r;
        @(negedge clk);
        chk(ov === e_valid, e_tag, "valid", int'(ov), int'(e_valid));
        if (e_valid) begin
            chk(oi === e_idx, e_tag, "index", int'(oi), int'(e_idx));
            chk(ob === e_bits, e_tag, "bits", int'(ob), int'(e_bits));
            if (e_sel >= 0) cap[e_sel][e_idx] = ob;
        end
        sym_start  = st;
        sym_active = act;
        seed       = t_seed;
        free_run   = t_free;
        used       = t_used;
        r = ref2(m_state);
        e_valid = m_run && t_used[m_idx];
        e_idx   = m_idx;
        e_bits  = (m_idx == '0) ? 2'b00 : r[12:11];
        e_sel   = cap_sel;
        if (m_run && m_idx == '0)       e_tag = "R4";
        else if (m_run && !t_used[m_idx]) e_tag = "R5";
        else                            e_tag = tag;
        if (st && act && !t_free) m_state = t_seed;
        else if (m_run)           m_state = r[10:0];
        if (st) begin
            m_run = act;
            m_idx = '0;
        end else if (m_run) begin
            if (m_idx == IW'(N - 1)) m_run = 1'b0;
            m_idx = m_idx + 1'b1;
        end
    endtask

    task automatic sym(input logic act);
        cyc(1'b1, act);
        repeat (N - 1) cyc(1'b0, 1'b0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        t_seed = 11'h5A3; t_free = 1'b0; t_used = '1;
        rst = 1'b1; sym_start = 1'b0; sym_active = 1'b0;
        free_run = 1'b0; seed = t_seed; used = t_used;
        cap_sel = -1; e_sel = -1; tag = "R1"; e_tag = "R1";
        repeat (3) @(negedge clk);
        chk(ov === 1'b0, "R1", "valid in reset", int'(ov), 0);
        rst = 1'b0;
        m_state = t_seed; m_run = 1'b0; m_idx = '0;
        e_valid = 1'b0; e_idx = '0; e_bits = '0;
        repeat (4) cyc(1'b0, 1'b0);

        // R2 / R3: first symbol starts from the reset seed
        tag = "R2";
        sym(1'b1);
        // R6: reseed mode repeats the sequence
        tag = "R6";
        cap_sel = 0; sym(1'b1);
        cap_sel = 1; sym(1'b1);
        cap_sel = -1; cyc(1'b0, 1'b0);
        begin
            bit same = 1'b1;
            for (int i = 0; i < N; i++) if (cap[0][i] !== cap[1][i]) same = 1'b0;
            chk(same, "R6", "symbols identical", int'(same), 1);
        end

        // R7: free-running continues
        tag = "R7"; t_free = 1'b1;
        cap_sel = 2; sym(1'b1);
        cap_sel = 3; sym(1'b1);
        cap_sel = -1; cyc(1'b0, 1'b0);
        begin
            bit diff = 1'b0;
            for (int i = 0; i < N; i++) if (cap[2][i] !== cap[3][i]) diff = 1'b1;
            chk(diff, "R7", "symbols differ", int'(diff), 1);
        end

        // R5: partial in-use mask
        tag = "R5"; t_used = 16'b1010_0110_1100_1011;
        sym(1'b1); sym(1'b1);
        t_free = 1'b0; sym(1'b1);
        t_used = '1; t_free = 1'b1;

        // R8: inactive positions and idle gaps freeze the register
        tag = "R8";
        sym(1'b0);
        repeat (5) cyc(1'b0, 1'b0);
        sym(1'b1);
        cyc(1'b1, 1'b0);
        repeat (3) cyc(1'b0, 1'b0);
        sym(1'b1);

        // R9: restart mid-symbol, both modes, and abort by inactive start
        tag = "R9";
        cyc(1'b1, 1'b1); repeat (5) cyc(1'b0, 1'b0);
        sym(1'b1);
        t_free = 1'b0;
        cyc(1'b1, 1'b1); repeat (6) cyc(1'b0, 1'b0);
        sym(1'b1);
        cyc(1'b1, 1'b1); repeat (3) cyc(1'b0, 1'b0);
        cyc(1'b1, 1'b0); repeat (4) cyc(1'b0, 1'b0);

        // R10: seed and mode changes mid-symbol take effect only at a start
        tag = "R10"; t_free = 1'b0;
        cyc(1'b1, 1'b1); repeat (4) cyc(1'b0, 1'b0);
        t_seed = 11'h0F1; t_free = 1'b1;
        repeat (N - 5) cyc(1'b0, 1'b0);
        sym(1'b1);
        cyc(1'b1, 1'b1); repeat (3) cyc(1'b0, 1'b0);
        t_free = 1'b0; t_seed = 11'h7FF;
        repeat (N - 4) cyc(1'b0, 1'b0);
        sym(1'b1);

        // R3: sweep over single-bit and mixed seeds in reseed mode
        tag = "R3";
        for (int k = 0; k < 11; k++) begin
            t_seed = 11'(1) << k;
            sym(1'b1);
        end
        t_seed = 11'h2C5; sym(1'b1);
        t_free = 1'b1;
        for (int k = 0; k < 6; k++) sym(1'b1);

        repeat (3) cyc(1'b0, 1'b0);
        finish_run();
    end

endmodule